// File: doc/BRIEF.md
# Dual-Width Quantized Dot-Product Lane

This block is one multiplier lane of a processing element in an integer transformer accelerator. It takes a vector of signed 8-bit activations and a packed word of 4-bit weight nibbles, and returns their signed dot product one clock later. The weight precision is chosen for each operation by a mode input. In narrow mode, every nibble is a separate signed 4-bit weight. In wide mode, adjacent nibble pairs are joined into signed 8-bit weights.

The lane contains four narrow partial multipliers, each 8 by 4 bits. In narrow mode they work independently and their four products are summed. In wide mode they are used in pairs. Both multipliers of a pair receive the same activation. The low-nibble product is taken with the nibble as unsigned. The high-nibble product is taken with the nibble as signed and is shifted left by four before the pair is added. Operands are symmetric and have no zero point, so no offset term is ever applied. Accumulation over several cycles is done by the surrounding processing element.

Top module: `dwd_dot_lane`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `dot_out` is 0, until the first accepted operation.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` is high, and is low otherwise.
- R3: When `wide_mode`=0, `dot_out` is the sum over i=0..3 of act_i times nib_i. Here act_i is `act_vec[8i+7:8i]` and nib_i is `wt_nibs[4i+3:4i]`, both two's complement.
- R4: When `wide_mode`=1, `dot_out` = act_0 × W0 + act_2 × W1. W0 is the signed byte {nib_1, nib_0} and W1 is the signed byte {nib_3, nib_2}.
- R5: When `wide_mode`=1, activation lanes 1 and 3 have no effect on `dot_out`.
- R6: In a cycle with `in_valid` low, all data and mode inputs are ignored, and `dot_out` keeps its previous value.
- R7: The mode may change between two back-to-back operations with no idle cycle, and each result follows the mode sampled with its own `in_valid`.
- R8: `dot_out` is a 20-bit two's complement value. It is exact at the operand extremes: narrow mode lies in -4064..4096 and wide mode lies in -32512..32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| wide_mode | input | 1 | 0: four 8x4 products; 1: two 8x8 products |
| act_vec | input | 32 | Four signed 8-bit activations, lane i at bits 8i+7:8i |
| wt_nibs | input | 16 | Four weight nibbles, nibble i at bits 4i+3:4i |
| out_valid | output | 1 | Result is valid |
| dot_out | output | 20 | Signed dot-product result |

## Verification
The embedded assertions check the valid timing, the holding of the output during idle cycles, and the result range for each registered mode on every cycle. The bench scenarios alone can show the arithmetic itself. That covers the exact signed sums in both modes, the unsigned treatment of the low nibble when pairs are fused, and the fact that the odd activation lanes have no effect in wide mode. It also covers the extreme operands and mode switches between back-to-back operations, where each result must match the mode that was sampled with it.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
    localparam int ACT_W = 8;
    localparam int NIB_W = 4;
    localparam int LANES = 4;
    localparam int OUT_W = 20;
    localparam int PROD_W = ACT_W + NIB_W + 1;

    typedef struct packed {
        logic                    vld;
        logic                    wide;
        logic signed [OUT_W-1:0] dot;
    } dwd_state_t;
endpackage

// File: rtl/dwd_part_mul.sv
module dwd_part_mul #(
    parameter int ACT_W = 8,
    parameter int NIB_W = 4,
    localparam int PROD_W = ACT_W + NIB_W + 1
) (
    input  logic signed [ACT_W-1:0]  act,
    input  logic        [NIB_W-1:0]  nib,
    input  logic                     nib_signed,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [NIB_W:0] w_ext;

    always_comb begin
        w_ext = {nib_signed & nib[NIB_W-1], nib};
        prod  = PROD_W'(act) * PROD_W'(w_ext);
    end
endmodule

// File: rtl/dwd_fuse_sum.sv
module dwd_fuse_sum #(
    parameter int LANES  = 4,
    parameter int PROD_W = 13,
    parameter int NIB_W  = 4,
    parameter int OUT_W  = 20
) (
    input  logic [LANES*PROD_W-1:0] prods,
    input  logic                    wide,
    output logic signed [OUT_W-1:0] sum
);
    logic signed [OUT_W-1:0] term [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_term
        logic signed [PROD_W-1:0] p;
        assign p = prods[i*PROD_W +: PROD_W];
        if (i % 2 == 1) begin : g_hi
            assign term[i] = wide ? (OUT_W'(p) <<< NIB_W) : OUT_W'(p);
        end else begin : g_lo
            assign term[i] = OUT_W'(p);
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + term[i];
        end
    end
endmodule

// File: rtl/dwd_dot_lane.sv
module dwd_dot_lane
    import dwd_pkg::*;
#(
    parameter int P_ACT_W = ACT_W,
    parameter int P_NIB_W = NIB_W,
    parameter int P_LANES = LANES,
    localparam int P_PROD_W = P_ACT_W + P_NIB_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       wide_mode,
    input  logic [P_LANES*P_ACT_W-1:0] act_vec,
    input  logic [P_LANES*P_NIB_W-1:0] wt_nibs,
    output logic                       out_valid,
    output logic [OUT_W-1:0]           dot_out
);
    localparam int A_MIN = -(2 ** (P_ACT_W - 1));
    localparam int A_MAX = (2 ** (P_ACT_W - 1)) - 1;
    localparam int N_MIN = -(2 ** (P_NIB_W - 1));
    localparam int N_MAX = (2 ** (P_NIB_W - 1)) - 1;
    localparam int W_MIN = -(2 ** (2 * P_NIB_W - 1));
    localparam int W_MAX = (2 ** (2 * P_NIB_W - 1)) - 1;
    localparam int NAR_HI = P_LANES * A_MIN * N_MIN;
    localparam int NAR_LO = P_LANES * ((A_MIN * N_MAX < A_MAX * N_MIN) ? A_MIN * N_MAX : A_MAX * N_MIN);
    localparam int WID_HI = (P_LANES / 2) * A_MIN * W_MIN;
    localparam int WID_LO = (P_LANES / 2) * ((A_MIN * W_MAX < A_MAX * W_MIN) ? A_MIN * W_MAX : A_MAX * W_MIN);

    logic [P_LANES*P_PROD_W-1:0] prods;
    logic signed [OUT_W-1:0]     sum;
    dwd_state_t                  st_d, st_q;

    for (genvar i = 0; i < P_LANES; i++) begin : g_mul
        localparam int PAIR_BASE = i - (i % 2);
        logic [P_ACT_W-1:0] act_sel;
        logic               nib_sgn;
        assign act_sel = wide_mode ? act_vec[PAIR_BASE*P_ACT_W +: P_ACT_W]
                                   : act_vec[i*P_ACT_W +: P_ACT_W];
        assign nib_sgn = !wide_mode || (i % 2 == 1);
        dwd_part_mul #(.ACT_W(P_ACT_W), .NIB_W(P_NIB_W)) part_i (
            .act        (act_sel),
            .nib        (wt_nibs[i*P_NIB_W +: P_NIB_W]),
            .nib_signed (nib_sgn),
            .prod       (prods[i*P_PROD_W +: P_PROD_W])
        );
    end

    dwd_fuse_sum #(.LANES(P_LANES), .PROD_W(P_PROD_W), .NIB_W(P_NIB_W), .OUT_W(OUT_W)) fuse_i (
        .prods (prods),
        .wide  (wide_mode),
        .sum   (sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.wide = wide_mode;
            st_d.dot  = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign dot_out   = st_q.dot;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dot_out));
    a_r8_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.wide) |->
            ($signed(dot_out) >= NAR_LO && $signed(dot_out) <= NAR_HI));
    a_r8_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.wide) |->
            ($signed(dot_out) >= WID_LO && $signed(dot_out) <= WID_HI));
endmodule

// File: tb/dwd_dot_lane_tb.sv
module dwd_dot_lane_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        wide_mode;
    logic [31:0] act_vec;
    logic [15:0] wt_nibs;
    logic        out_valid;
    logic [19:0] dot_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dwd_dot_lane dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide_mode (wide_mode),
        .act_vec   (act_vec),
        .wt_nibs   (wt_nibs),
        .out_valid (out_valid),
        .dot_out   (dot_out)
    );

    function automatic int exp_dot(bit wide, logic [31:0] a, logic [15:0] n);
        int s = 0;
        if (!wide) begin
            for (int i = 0; i < 4; i++)
                s += int'($signed(a[8*i +: 8])) * int'($signed(n[4*i +: 4]));
        end else begin
            s = int'($signed(a[7:0])) * int'($signed(n[7:0]))
              + int'($signed(a[23:16])) * int'($signed(n[15:8]));
        end
        return s;
    endfunction

    task automatic check(string tag, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one operation: drive at negedge, sample one cycle later
    task automatic run_op(string tag, bit wide, logic [31:0] a, logic [15:0] n);
        @(negedge clk);
        in_valid = 1'b1; wide_mode = wide; act_vec = a; wt_nibs = n;
        @(posedge clk); #1;
        check({tag, " valid"}, int'(out_valid), 1);
        check(tag, int'($signed(dot_out)), exp_dot(wide, a, n));
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; wide_mode = 1'b0; act_vec = '0; wt_nibs = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 dot in reset", int'(dot_out), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 dot after reset", int'(dot_out), 0);
    endtask

    task automatic t_narrow();
        run_op("R3 simple", 1'b0, 32'h04_03_02_01, 16'h1111);
        run_op("R3 mixed sign", 1'b0, 32'hF0_7F_80_05, 16'h9_7_3_E);
        for (int k = 0; k < 40; k++) run_op("R3 random", 1'b0, $urandom, 16'($urandom));
        go_idle();
        @(posedge clk); #1;
        check("R2 valid drops", int'(out_valid), 0);
    endtask

    task automatic t_wide();
        run_op("R4 simple", 1'b1, 32'h00_03_00_02, 16'h0105);
        run_op("R4 low nibble unsigned", 1'b1, 32'h00_01_00_01, 16'h0F_0F);
        run_op("R4 negative weights", 1'b1, 32'h00_7F_00_C0, 16'hF8_81);
        for (int k = 0; k < 40; k++) run_op("R4 random", 1'b1, $urandom, 16'($urandom));
        go_idle();
    endtask

    task automatic t_odd_ignored();
        int r1;
        run_op("R5 base", 1'b1, 32'h00_11_00_22, 16'h3C_A5);
        r1 = int'($signed(dot_out));
        run_op("R5 odd lanes changed", 1'b1, 32'h7F_11_80_22, 16'h3C_A5);
        check("R5 odd lanes no effect", int'($signed(dot_out)), r1);
        go_idle();
    endtask

    task automatic t_hold();
        int r1;
        run_op("R6 setup", 1'b0, 32'h05_06_07_08, 16'h2222);
        r1 = int'($signed(dot_out));
        @(negedge clk);
        in_valid = 1'b0; wide_mode = 1'b1; act_vec = 32'h80808080; wt_nibs = 16'h8888;
        @(posedge clk); #1;
        check("R6 valid low", int'(out_valid), 0);
        check("R6 dot held", int'($signed(dot_out)), r1);
        @(posedge clk); #1;
        check("R6 dot held second cycle", int'($signed(dot_out)), r1);
    endtask

    task automatic t_switch();
        run_op("R7 narrow first", 1'b0, 32'h10_20_30_40, 16'h1234);
        run_op("R7 wide next", 1'b1, 32'h10_20_30_40, 16'h1234);
        run_op("R7 narrow again", 1'b0, 32'h10_20_30_40, 16'h1234);
        run_op("R7 wide again", 1'b1, 32'hFF_FF_FF_FF, 16'hFFFF);
        go_idle();
    endtask

    task automatic t_extremes();
        run_op("R8 narrow max", 1'b0, 32'h80808080, 16'h8888);
        check("R8 narrow max value", int'($signed(dot_out)), 4096);
        run_op("R8 narrow min", 1'b0, 32'h7F7F7F7F, 16'h8888);
        check("R8 narrow min value", int'($signed(dot_out)), -4064);
        run_op("R8 wide max", 1'b1, 32'h00800080, 16'h8080);
        check("R8 wide max value", int'($signed(dot_out)), 32768);
        run_op("R8 wide min", 1'b1, 32'h007F007F, 16'h8080);
        check("R8 wide min value", int'($signed(dot_out)), -32512);
        go_idle();
    endtask

    initial begin
        t_reset();
        t_narrow();
        t_wide();
        t_odd_ignored();
        t_hold();
        t_switch();
        t_extremes();
        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                end
            end
            wait (done);
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule